// File: doc/BRIEF.md
# Audio Frame Step Sequencer

This block produces the slow housekeeping strobes of a sound generator. A divider counts a fixed number of system clocks per tick, which is about 240 Hz at the intended clock. Each tick advances a looping step sequencer. The sequencer emits two strobes: a quarter-frame strobe that clocks envelopes and the linear counter, and a half-frame strobe that clocks length counters and sweep units. In one of its two sequences the sequencer also raises an interrupt flag.

A CPU-side control write chooses between a 4-step and a 5-step sequence and sets an IRQ-disable bit. Every control write restarts the divider and the sequencer. A 5-step write also performs the first step straight away. Software reads the interrupt flag through a status byte, and reading the status clears the flag. The IRQ output is driven whenever the flag is set and interrupts are enabled. The units that consume the strobes are not part of this block.

Top module: `audio_frame_seq`

## Requirements
- R1: After synchronous reset the block is in 4-step mode with IRQ enabled and the flag clear. No strobe, flag or IRQ appears before the first tick, and that tick comes DIV_PERIOD clocks after reset, exactly as after a write of 0x00.
- R2: A tick occurs every DIV_PERIOD system clocks. The period is the same in both modes.
- R3: Every control write resets the divider and the step position, whatever they held before. Only bit 7 (mode: 0 = 4-step, 1 = 5-step) and bit 6 (IRQ disable) have an effect; bits 5..0 are ignored.
- R4: In 4-step mode, step 1 is pulsed in the cycle that is DIV_PERIOD clocks after the write cycle. The steps then loop 1,2,3,4, one tick apart. Every step pulses the quarter-frame strobe, and steps 2 and 4 also pulse the half-frame strobe.
- R5: In 5-step mode, step 1 is pulsed in the cycle right after the write cycle, and the later steps follow one tick apart. Steps 1 and 3 pulse both strobes, steps 2 and 4 pulse only the quarter-frame strobe, and step 5 pulses neither. The sequence then loops.
- R6: In 4-step mode, step 4 sets the interrupt flag. The flag becomes visible one cycle after the step-4 strobe, as bit 6 of the status byte; all other status bits read 0.
- R7: The interrupt flag is never set while the block is in 5-step mode.
- R8: The IRQ output equals the flag AND NOT the IRQ-disable bit.
- R9: A status read clears the flag in the next cycle, and so does a control write with bit 6 set. If a step-4 event arrives in the same cycle, setting the flag takes priority.
- R10: Each strobe pulse lasts a single clock cycle, unless control writes arrive on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| ctrlWe | input | 1 | Control write strobe |
| ctrlData | input | 8 | Control byte: bit 7 mode, bit 6 IRQ disable |
| statRe | input | 1 | Status read strobe (clears the flag) |
| statData | output | 8 | Status byte: bit 6 is the interrupt flag |
| quarterStb | output | 1 | Quarter-frame strobe |
| halfStb | output | 1 | Half-frame strobe |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with DIV_PERIOD = 7. With that value, several full loops of both sequences fit in about a hundred cycles, so every cycle of each run can be compared against a step position computed arithmetically from the cycle count since the write. The sweep covers both modes, both IRQ-disable settings and several values of the ignored low bits. Each run restarts from whatever divider phase the previous run left behind. Dedicated cases cover clearing the flag by a status read and by a disabling write.

// File: rtl/afs_pkg.sv
package afs_pkg;
  typedef struct packed {
    logic quarter;
    logic half;
    logic frameEvt;
  } seq_evt_t;
endpackage

// File: rtl/afs_ctrl.sv
module afs_ctrl #(
  parameter int DIV_PERIOD = 89490
) (
  input  logic clk,
  input  logic rst,
  input  logic ctrlWe,
  input  logic ctrlData7,
  output afs_pkg::seq_evt_t evt
);
  import afs_pkg::*;
  localparam int CW = $clog2(DIV_PERIOD);
  localparam logic [CW-1:0] LAST_CNT = CW'(DIV_PERIOD - 1);

  logic [CW-1:0] divCnt;
  logic [2:0]    stepIdx;
  logic          fiveStep;

  function automatic seq_evt_t decodeStep(input logic five, input logic [2:0] idx);
    seq_evt_t e;
    if (five) begin
      e.quarter  = (idx < 3'd4);
      e.half     = (idx == 3'd0) || (idx == 3'd2);
      e.frameEvt = 1'b0;
    end else begin
      e.quarter  = 1'b1;
      e.half     = idx[0];
      e.frameEvt = (idx == 3'd3);
    end
    return e;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt   <= '0;
      stepIdx  <= '0;
      fiveStep <= 1'b0;
      evt      <= '0;
    end else begin
      evt <= '0;
      if (ctrlWe) begin
        divCnt   <= '0;
        fiveStep <= ctrlData7;
        if (ctrlData7) begin
          evt     <= decodeStep(1'b1, 3'd0);
          stepIdx <= 3'd1;
        end else begin
          stepIdx <= 3'd0;
        end
      end else if (divCnt == LAST_CNT) begin
        divCnt  <= '0;
        evt     <= decodeStep(fiveStep, stepIdx);
        stepIdx <= (stepIdx == (fiveStep ? 3'd4 : 3'd3)) ? 3'd0 : stepIdx + 3'd1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // R5
  five_write_chk: assert property (@(posedge clk) disable iff (rst)
    ctrlWe && ctrlData7 |=> evt.quarter && evt.half);
  // R4
  four_write_chk: assert property (@(posedge clk) disable iff (rst)
    ctrlWe && !ctrlData7 |=> !evt.quarter && !evt.half);
  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    evt.quarter && !ctrlWe |=> !evt.quarter);
  // R7
  no_frame_five_chk: assert property (@(posedge clk) disable iff (rst)
    evt.frameEvt |-> !fiveStep);
endmodule

// File: rtl/afs_datapath.sv
module afs_datapath (
  input  logic clk,
  input  logic rst,
  input  logic ctrlWe,
  input  logic ctrlData6,
  input  logic statRe,
  input  afs_pkg::seq_evt_t evt,
  output logic [7:0] statData,
  output logic irqOut
);
  logic flag;
  logic irqDis;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      irqDis <= 1'b0;
    end else begin
      if (ctrlWe) irqDis <= ctrlData6;
      if (evt.frameEvt) flag <= 1'b1;
      else if (statRe || (ctrlWe && ctrlData6)) flag <= 1'b0;
    end
  end

  assign statData = {1'b0, flag, 6'b0};
  assign irqOut   = flag & ~irqDis;

  // R6
  flag_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(evt.frameEvt));
  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    statRe && !evt.frameEvt |=> !statData[6]);
  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    ctrlWe && ctrlData6 |=> !irqOut);
endmodule

// File: rtl/audio_frame_seq.sv
module audio_frame_seq #(
  parameter int DIV_PERIOD = 89490
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrlWe,
  input  logic [7:0] ctrlData,
  input  logic       statRe,
  output logic [7:0] statData,
  output logic       quarterStb,
  output logic       halfStb,
  output logic       irqOut
);
  afs_pkg::seq_evt_t evt;

  afs_ctrl #(.DIV_PERIOD(DIV_PERIOD)) uCtrl (
    .clk(clk), .rst(rst), .ctrlWe(ctrlWe), .ctrlData7(ctrlData[7]), .evt(evt)
  );

  afs_datapath uData (
    .clk(clk), .rst(rst), .ctrlWe(ctrlWe), .ctrlData6(ctrlData[6]),
    .statRe(statRe), .evt(evt), .statData(statData), .irqOut(irqOut)
  );

  assign quarterStb = evt.quarter;
  assign halfStb    = evt.half;
endmodule

// File: tb/tb_audio_frame_seq.sv
module tb_audio_frame_seq;
  localparam int DIV = 7;
  localparam int RUN = 105;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrlWe = 1'b0;
  logic [7:0] ctrlData = '0;
  logic statRe = 1'b0;
  logic [7:0] statData;
  logic quarterStb, halfStb, irqOut;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  audio_frame_seq #(.DIV_PERIOD(DIV)) dut (
    .clk(clk), .rst(rst), .ctrlWe(ctrlWe), .ctrlData(ctrlData), .statRe(statRe),
    .statData(statData), .quarterStb(quarterStb), .halfStb(halfStb), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // checks RUN cycles from t=0 (the cycle right after the write edge)
  task automatic runSeq(input bit five, input bit dis, input string tag);
    for (int t = 0; t < RUN; t++) begin
      bit q, h, f;
      int s;
      q = 0; h = 0; f = 0;
      if (five) begin
        if (t % DIV == 0) begin
          s = (t / DIV) % 5 + 1;
          q = (s <= 4);
          h = (s == 1) || (s == 3);
        end
      end else begin
        if (t > 0 && t % DIV == 0) begin
          s = ((t / DIV) - 1) % 4 + 1;
          q = 1;
          h = (s == 2) || (s == 4);
        end
        f = (t >= 4 * DIV + 1);
      end
      chk({tag, " quarter R2 R4 R5"}, quarterStb, q);
      chk({tag, " half R4 R5"}, halfStb, h);
      chk({tag, " status R6 R7"}, statData, f ? 8'h40 : 8'h00);
      chk({tag, " irq R8"}, irqOut, f && !dis);
      @(negedge clk);
    end
  endtask

  task automatic doWrite(input logic [7:0] v);
    ctrlWe = 1'b1; ctrlData = v;
    @(negedge clk);
    ctrlWe = 1'b0; ctrlData = '0;
  endtask

  task automatic doRead();
    statRe = 1'b1;
    @(negedge clk);
    statRe = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset status", statData, 0);
    chk("R1 reset irq", irqOut, 0);
    rst = 1'b0;
    runSeq(1'b0, 1'b0, "R1 after reset");
    doRead();
    // R3: sweep over mode, disable and ignored low bits
    for (int m = 0; m < 2; m++)
      for (int d = 0; d < 2; d++)
        for (int lb = 0; lb < 3; lb++) begin
          logic [7:0] v;
          v = {m[0], d[0], (lb == 0) ? 6'h00 : (lb == 1) ? 6'h3F : 6'h15};
          doWrite(v);
          runSeq(m[0], d[0], $sformatf("R3 ctrl=%02h", v));
          doRead();
        end
    // R9: status read clears a set flag
    doWrite(8'h00);
    runSeq(1'b0, 1'b0, "R9 prep");
    chk("R9 flag set before read", statData, 8'h40);
    doRead();
    chk("R9 read clears flag", statData, 0);
    chk("R9 irq after read", irqOut, 0);
    // R9: disabling write clears the flag
    doWrite(8'h00);
    runSeq(1'b0, 1'b0, "R9 prep2");
    doWrite(8'h40);
    chk("R9 disable write clears flag", statData, 0);
    chk("R8 irq after disable write", irqOut, 0);
    // R10: consecutive cycles without a strobe after a 5-step write
    doWrite(8'h80);
    chk("R10 pulse high", quarterStb, 1);
    @(negedge clk);
    chk("R10 pulse single cycle", quarterStb, 0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule